// File: doc/BRIEF.md
# Wakeup-Capable Edge/Level Interrupt Port

This block watches a bank of external interrupt pins. Each pin is set to one of four trigger kinds: a held low level, a rising edge, a falling edge or either edge. Each pin also has an enable bit and a sticky event flag. Flags are recorded for every pin whatever its enable. Enabled flags drive an interrupt request. The same request, or a low level on an enabled level-mode pin, drives a wakeup line toward the power controller. Software reaches the block through a small write/read register port. Flags are cleared by writing ones.

A power-mode input tells the block which low-power mode the device is in. In run, wait and doze modes, edge and level detection behave the same way. In stop mode the system clock is taken to be absent. The synchroniser and the detectors freeze, and no flag changes. The wakeup output stays alive because it has a purely combinational term: a raw pin that is low, in level mode and enabled. When the device leaves stop, the synchroniser pipeline still holds values from before stop. A short resume phase flushes those stale values so that the change does not look like a false edge.

A small power-state machine runs this behaviour. It has four states:
- ACTIVE: run mode, detection armed.
- IDLE: wait or doze mode, detection armed.
- FROZEN: stop mode, synchroniser halted, detection disarmed.
- RESUME: flush after stop, synchroniser running, detection disarmed.

Its transitions are:
- ACTIVE↔IDLE, following the mode input.
- ACTIVE/IDLE→FROZEN, when stop is requested.
- FROZEN→RESUME, when stop is released.
- RESUME→FROZEN, when stop comes back during the flush.
- RESUME→ACTIVE/IDLE, after SYNC_STAGES+1 cycles.

Top module: `wakeup_irq_port`

## Requirements
- R1: After reset the trigger register, the enable register, the flags, `irq_o` and `wake_o` all read zero, provided every pin is high.
- R2: Register addresses are as follows. Address 0 is the trigger register; pin i uses bits [2i+1:2i], where code 0 means low level, 1 rising, 2 falling and 3 both edges. Address 1 is the enable register, with bit i for pin i. Address 2 is the flag register, with bit i for pin i. Address 3 reads zero. Reads are combinational.
- R3: In run, wait or doze mode, an edge of the configured kind sets the pin's flag on the third rising clock edge after the pin changes. It is not set on the second. An edge of the other direction on a single-direction pin sets nothing.
- R4: Writing ones to address 2 clears the matching edge-mode flags. Zero bits leave flags unchanged.
- R5: A level-mode pin whose synchronised value is low has its flag set. Writing one to that flag does not clear it while the pin stays low. Once the pin is high, the write clears it.
- R6: `irq_o` is high exactly when some flag is set and its pin is enabled. A disabled pin still records its flag but does not raise `irq_o`.
- R7: Power mode encoding on `pmode_i` is 0 run, 1 wait, 2 doze and 3 stop. While in stop, pin activity sets no flag.
- R8: `wake_o` is high whenever any raw pin is low, in level mode and enabled, with no clock edge needed. It is also high whenever `irq_o` is high.
- R9: After stop is released, a pin change made during stop or at the moment of release sets no edge flag. An edge made once the flush has finished is flagged as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pmode_i | input | 2 | Power mode: 0 run, 1 wait, 2 doze, 3 stop |
| pin_i | input | NUM_PINS (8) | External interrupt pins, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 2*NUM_PINS (16) | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 2*NUM_PINS (16) | Register read data, zero-extended |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request to the power controller |

## Verification
The bench builds the block with its defaults: eight pins and a two-stage synchroniser. This gives two pins of each trigger kind at once, so one random pin vector exercises level, rising, falling and both-edge detection side by side. The two-stage depth makes the three-edge detection latency and the three-cycle post-stop flush short enough to probe cycle by cycle. Random phases mix pin vectors, enables, trigger codes, run/wait/doze modes and clear masks. Directed phases cover the latency boundary, the write-one clear on level pins, and the clockless stop wakeup. They also cover a pin change placed exactly at stop release.

// File: rtl/wip_pkg.sv
package wip_pkg;

    // Per-pin trigger kind, two bits per pin in the trigger register
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_e;

    // Power mode input encoding
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_DOZE = 2'd2,
        PM_STOP = 2'd3
    } pmode_e;

    // Power-state machine states
    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_IDLE   = 2'd1,
        PS_FROZEN = 2'd2,
        PS_RESUME = 2'd3
    } pstate_e;

    localparam int          ADDR_W    = 2;
    localparam logic [1:0]  ADDR_TRIG = 2'd0;
    localparam logic [1:0]  ADDR_EN   = 2'd1;
    localparam logic [1:0]  ADDR_FLAG = 2'd2;

endpackage

// File: rtl/wip_pwr_fsm.sv
module wip_pwr_fsm
    import wip_pkg::*;
#(
    parameter int RESUME_CYC = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] pmode_i,
    output logic       arm_o,
    output logic       sync_run_o
);

    localparam int                CNT_W    = $clog2(RESUME_CYC + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(RESUME_CYC - 1);

    pstate_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             want_stop, want_run;

    assign want_stop = (pmode_i == PM_STOP);
    assign want_run  = (pmode_i == PM_RUN);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PS_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_ACTIVE: begin
                if (want_stop)      state_d = PS_FROZEN;
                else if (!want_run) state_d = PS_IDLE;
            end
            PS_IDLE: begin
                if (want_stop)      state_d = PS_FROZEN;
                else if (want_run)  state_d = PS_ACTIVE;
            end
            PS_FROZEN: begin
                if (!want_stop) begin
                    state_d = PS_RESUME;
                    cnt_d   = '0;
                end
            end
            PS_RESUME: begin
                if (want_stop) begin
                    state_d = PS_FROZEN;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = want_run ? PS_ACTIVE : PS_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = PS_ACTIVE;
        endcase
    end

    // Outputs
    always_comb begin
        arm_o      = 1'b0;
        sync_run_o = 1'b1;
        unique case (state_q)
            PS_ACTIVE: arm_o = 1'b1;
            PS_IDLE:   arm_o = 1'b1;
            PS_FROZEN: sync_run_o = 1'b0;
            PS_RESUME: arm_o = 1'b0;
            default:   arm_o = 1'b0;
        endcase
    end

    // R9
    stop_release_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PS_FROZEN && !want_stop) |=> (state_q == PS_RESUME));

    // R7
    stop_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        want_stop |=> !arm_o);

endmodule

// File: rtl/wip_sync.sv
module wip_sync #(
    parameter int NUM_PINS = 8,
    parameter int STAGES   = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                run_i,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] sync_o,
    output logic [NUM_PINS-1:0] prev_o
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else if (run_i) begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[i]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign sync_o[i] = chain_q[STAGES-1];
        assign prev_o[i] = prev_q;
    end

endmodule

// File: rtl/wip_flags.sv
module wip_flags
    import wip_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  arm_i,
    input  logic [NUM_PINS-1:0]   sync_i,
    input  logic [NUM_PINS-1:0]   prev_i,
    input  logic [2*NUM_PINS-1:0] trig_i,
    input  logic [NUM_PINS-1:0]   clr_i,
    output logic [NUM_PINS-1:0]   flag_o
);

    logic [NUM_PINS-1:0] flag_q;
    logic [NUM_PINS-1:0] lvl_low;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [1:0] code;
        logic       rise, fall, hit, is_lvl, clr_ok;

        assign code   = trig_i[2*i +: 2];
        assign is_lvl = (code == TRIG_LOW);
        assign rise   = sync_i[i] & ~prev_i[i];
        assign fall   = ~sync_i[i] & prev_i[i];

        always_comb begin
            unique case (code)
                TRIG_LOW:  hit = ~sync_i[i];
                TRIG_RISE: hit = rise;
                TRIG_FALL: hit = fall;
                TRIG_BOTH: hit = rise | fall;
                default:   hit = 1'b0;
            endcase
        end

        // Level flags only clear once the synchronised pin is high again
        assign clr_ok     = clr_i[i] & (~is_lvl | sync_i[i]);
        assign lvl_low[i] = is_lvl & ~sync_i[i];

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) flag_q[i] <= 1'b0;
            else         flag_q[i] <= (arm_i & hit) | (flag_q[i] & ~clr_ok);
        end
    end

    assign flag_o = flag_q;

    // R7
    no_set_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> ((flag_q & ~$past(flag_q)) == '0));

    // R5
    level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && (lvl_low != '0)) |=> ((flag_q & $past(lvl_low)) == $past(lvl_low)));

endmodule

// File: rtl/wakeup_irq_port.sv
module wakeup_irq_port
    import wip_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [1:0]              pmode_i,
    input  logic [NUM_PINS-1:0]     pin_i,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [2*NUM_PINS-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic [2*NUM_PINS-1:0]   rd_data_o,
    output logic                    irq_o,
    output logic                    wake_o
);

    localparam int DATA_W     = 2 * NUM_PINS;
    localparam int RESUME_CYC = SYNC_STAGES + 1;

    logic [DATA_W-1:0]   trig_q;
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] flags;
    logic [NUM_PINS-1:0] clr;
    logic [NUM_PINS-1:0] sync_v, prev_v;
    logic [NUM_PINS-1:0] lvl_mask;
    logic [NUM_PINS-1:0] raw_lvl_wake;
    logic                arm, sync_run;

    // Configuration registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trig_q <= '0;
            en_q   <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_TRIG) trig_q <= wr_data_i;
            if (wr_addr_i == ADDR_EN)   en_q   <= wr_data_i[NUM_PINS-1:0];
        end
    end

    assign clr = (wr_en_i && wr_addr_i == ADDR_FLAG) ? wr_data_i[NUM_PINS-1:0] : '0;

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            ADDR_TRIG: rd_data_o = trig_q;
            ADDR_EN:   rd_data_o[NUM_PINS-1:0] = en_q;
            ADDR_FLAG: rd_data_o[NUM_PINS-1:0] = flags;
            default:   rd_data_o = '0;
        endcase
    end

    wip_pwr_fsm #(.RESUME_CYC(RESUME_CYC)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pmode_i    (pmode_i),
        .arm_o      (arm),
        .sync_run_o (sync_run)
    );

    wip_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (sync_run),
        .pin_i  (pin_i),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    wip_flags #(.NUM_PINS(NUM_PINS)) u_flags (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (arm),
        .sync_i (sync_v),
        .prev_i (prev_v),
        .trig_i (trig_q),
        .clr_i  (clr),
        .flag_o (flags)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_lvl
        assign lvl_mask[i] = (trig_q[2*i +: 2] == TRIG_LOW);
    end

    // Clockless wakeup path: raw pin, no synchroniser
    assign raw_lvl_wake = ~pin_i & lvl_mask & en_q;
    assign irq_o        = |(flags & en_q);
    assign wake_o       = (|raw_lvl_wake) | irq_o;

    // R6
    irq_implies_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> wake_o);

    // R8
    level_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~pin_i & lvl_mask & en_q) != '0) |-> wake_o);

endmodule

// File: tb/tb_wakeup_irq_port.sv
module tb_wakeup_irq_port;
    localparam int N = 8;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   pmode = 2'd0;
    logic [N-1:0] pins = '1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = 2'd0;
    logic [W-1:0] rd_data;
    logic         irq, wake;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_trig = '0;
    logic [N-1:0] m_en = '0;
    logic [N-1:0] m_flag = '0;

    always #5 clk = ~clk;

    wakeup_irq_port #(.NUM_PINS(N), .SYNC_STAGES(2)) dut (
        .clk_i(clk), .rst_ni(rst_n), .pmode_i(pmode), .pin_i(pins),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .wake_o(wake)
    );

    function automatic logic [N-1:0] lvl_of(input logic [W-1:0] t);
        for (int i = 0; i < N; i++) lvl_of[i] = (t[2*i +: 2] == 2'd0);
    endfunction

    // Flags a settled pin change should set (level pins: set while low)
    function automatic logic [N-1:0] hits(input logic [N-1:0] o, input logic [N-1:0] n,
                                          input logic [W-1:0] t);
        for (int i = 0; i < N; i++) begin
            case (t[2*i +: 2])
                2'd0: hits[i] = !n[i];
                2'd1: hits[i] = !o[i] && n[i];
                2'd2: hits[i] = o[i] && !n[i];
                default: hits[i] = o[i] != n[i];
            endcase
        end
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [W-1:0] exp);
        rd_addr = a;
        #1;
        chk(req, "read", 32'(rd_data), 32'(exp));
    endtask

    task automatic out_chk(input string req);
        logic exp_irq;
        exp_irq = |(m_flag & m_en);
        rd_chk(req, 2'd2, W'(m_flag));
        chk(req, "irq", 32'(irq), 32'(exp_irq));
        chk(req, "wake", 32'(wake), 32'(exp_irq | (|(~pins & lvl_of(m_trig) & m_en))));
    endtask

    task automatic step(input logic [N-1:0] nv, input bit armed);
        logic [N-1:0] old;
        old = pins;
        @(negedge clk);
        pins = nv;
        repeat (4) @(negedge clk);
        if (armed) m_flag = m_flag | hits(old, nv, m_trig);
    endtask

    task automatic clear(input logic [N-1:0] m);
        wr(2'd2, W'(m));
        m_flag = (m_flag & ~m) | (lvl_of(m_trig) & ~pins & m_flag);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1", 2'd0, '0);
        rd_chk("R1", 2'd1, '0);
        out_chk("R1");

        // R2 register map
        wr(2'd0, 16'hE4E4); m_trig = 16'hE4E4;
        rd_chk("R2", 2'd0, 16'hE4E4);
        wr(2'd1, 16'hFFFF); m_en = 8'hFF;
        rd_chk("R2", 2'd1, 16'h00FF);
        rd_chk("R2", 2'd3, 16'h0000);

        // R3 latency on falling pin 2
        @(negedge clk);
        pins[2] = 1'b0;
        @(negedge clk); @(negedge clk);
        rd_addr = 2'd2; #1;
        chk("R3", "flag after 2 edges", 32'(rd_data[2]), 32'd0);
        @(negedge clk); #1;
        chk("R3", "flag after 3 edges", 32'(rd_data[2]), 32'd1);
        repeat (2) @(negedge clk);
        m_flag = 8'h04;
        out_chk("R3");

        // R4 zero write no effect, then clear
        clear(8'h00);
        out_chk("R4");
        clear(8'h04);
        out_chk("R4");
        // R3 wrong direction: rising on falling-only pin 2
        step(8'hFF, 1'b1);
        out_chk("R3");

        // R5 level pin 0 held low survives clear
        step(8'hFE, 1'b1);
        out_chk("R5");
        clear(8'h01);
        out_chk("R5");
        step(8'hFF, 1'b1);
        clear(8'h01);
        out_chk("R5");

        // R6 disabled pin records flag, no irq
        wr(2'd1, 16'h00FD); m_en = 8'hFD;
        step(8'hFD, 1'b1);
        out_chk("R6");
        step(8'hFF, 1'b1);
        clear(8'hFF);
        wr(2'd1, 16'h00FF); m_en = 8'hFF;
        out_chk("R6");

        // R7 / R8 stop mode
        @(negedge clk); pmode = 2'd3;
        repeat (2) @(negedge clk);
        pins[0] = 1'b0; #1;
        chk("R8", "clockless wake", 32'(wake), 32'd1);
        step(8'hF6, 1'b0);
        out_chk("R7");
        pins[0] = 1'b1; #1;
        chk("R8", "wake drops", 32'(wake), 32'd0);
        // R9 release with a change at the release moment on pin 7
        @(negedge clk); pmode = 2'd0; pins[7] = 1'b0;
        repeat (6) @(negedge clk);
        out_chk("R9");
        step(8'hFF, 1'b1);
        out_chk("R9");
        clear(8'hFF);

        // Random phase
        for (int it = 0; it < 300; it++) begin
            if (it % 20 == 0) begin
                logic [W-1:0] t;
                t = W'($urandom);
                wr(2'd0, t); m_trig = t;
                repeat (3) @(negedge clk);
                m_flag = m_flag | (lvl_of(m_trig) & ~pins);
            end
            if (it % 7 == 0) begin
                logic [N-1:0] e;
                e = N'($urandom);
                wr(2'd1, W'(e)); m_en = e;
            end
            pmode = 2'($urandom_range(2, 0));
            step(N'($urandom), 1'b1);
            out_chk("R3");
            if (it % 3 == 0) begin
                clear(N'($urandom));
                out_chk("R4");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule